// File: doc/BRIEF.md
# Flash Sector Write-Guard

This block keeps the write-protection state of an 8-Mbit serial flash. The array is split into 19 physical sectors of unequal size. Fifteen 64 KB sectors fill the lower part of the array. The top 64 KB is split into a 16 KB sector, two 8 KB sectors and a 32 KB boot sector. Each sector has one guard bit. The block turns any 24-bit byte address into the index of the sector that holds it. It then reports whether a pending program or erase would touch a guarded sector.

The command controller does the SPI shifting and decodes the opcodes. It passes this block one-cycle strobes for "guard sector", "unguard sector" and "status write", along with the address, a flag that says all three address bytes arrived, and the data byte. Status writes also control a lock bit. While the lock bit is set, the per-sector guard bits are frozen. The lock bit can be cleared only while the write-protect pin is released.

The outputs are:
- a refusal flag for the program or erase under test;
- a pulse asking the controller to clear its write-enable latch;
- the lock bit;
- a two-bit summary field;
- a per-sector read-back bit.

All of these are plain control and status pins. No stream moves through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `sg_sector_guard`

## Requirements
- R1: Address bits 19:0 choose the sector and bits 23:20 are ignored. Blocks 0 to 14 (addr[19:16]) are sectors 0 to 14. In the top 64 KB, offsets 0000h-3FFFh are sector 15, 4000h-5FFFh are sector 16, 6000h-7FFFh are sector 17, and 8000h-FFFFh are sector 18. `rb_prot` shows the guard bit of the sector that holds `rb_addr`.
- R2: A guard or unguard strobe changes state only when `wel` is 1, `cmd_addr_full` is 1 and the lock bit is 0. In that case the clock edge sets (guard) or clears (unguard) the bit of the addressed sector. If `cmd_addr_full` is 0, the strobe is discarded.
- R3: After reset, every guard bit is 1, the lock bit is 0 and `swp` is 11.
- R4: With the lock bit at 0, a status write with `wel` set behaves as follows. Data 00h clears every guard bit. Data with bits 5, 4, 3 and 2 all at 1 sets every guard bit. Any other value leaves the guard bits unchanged.
- R5: While the lock bit is 1, no guard, unguard or status write changes any guard bit.
- R6: Data bit 7 of an accepted status write becomes the lock bit. If the lock bit is 1 and `wp_n` is 0 (pin asserted), the whole status write is rejected and the lock bit stays 1. If the lock bit is 1 and `wp_n` is 1, the write may clear the lock bit.
- R7: `swp` is 00 when no sector is guarded, 01 when some are, and 11 when all are. The value 10 never appears.
- R8: For `chk_kind` 000 (program) and 001 (4 KB erase), `chk_prot` is the guard bit of the sector that holds `chk_addr`.
- R9: For `chk_kind` 010 (32 KB erase) and 011 (64 KB erase), the block is the aligned span that contains `chk_addr`. For 100 (chip erase) and codes 101-111, the span is the whole array. `chk_prot` is 1 if any sector that overlaps the span is guarded. This covers a 64 KB erase over the boot area.
- R10: `wel_clr` is 1 in the cycle of any status write with `wel` set. It is also 1 in the cycle of any guard or unguard strobe with `wel` and `cmd_addr_full` set, even while the lock bit is 1. It is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wel | input | 1 | Write-enable latch state from the controller |
| wp_n | input | 1 | Write-protect pin, 0 = asserted |
| cmd_prot | input | 1 | Guard-sector strobe |
| cmd_unprot | input | 1 | Unguard-sector strobe |
| cmd_addr_full | input | 1 | All three address bytes were received |
| cmd_addr | input | 24 | Address for the guard and unguard strobes |
| sr_wr | input | 1 | Status-write strobe (takes priority over the sector strobes) |
| sr_data | input | 8 | Status-write data byte |
| wel_clr | output | 1 | Request to clear the write-enable latch |
| lock | output | 1 | Lock bit |
| swp | output | 2 | Summary: 00 none, 01 some, 11 all guarded |
| chk_kind | input | 3 | Kind of the operation under test |
| chk_addr | input | 24 | Target address of the operation under test |
| chk_prot | output | 1 | Operation touches a guarded sector and must be refused |
| rb_addr | input | 24 | Read-back address |
| rb_prot | output | 1 | Guard bit of the sector that holds `rb_addr` |

## Verification
The hardest state to reach from the ports is a set lock bit combined with a released write-protect pin. In that state a single status write of 00h must clear the lock bit but must still refuse the global unguard it would otherwise cause. The stimulus first sets the lock with data 80h. It then sends 00h while the pin is asserted, to show that the write is rejected. Next it releases the pin and sends 00h again, to show that the lock clears while every guard bit stays put. A third 00h write then unguards the whole array. The bench also guards only the small boot sectors, so that the 32 KB and 64 KB span checks must find a guarded sector that is not at the start address.

// File: rtl/sg_pkg.sv
package sg_pkg;
  localparam int MEM_AW    = 20;
  localparam int UNI_LOG2  = 16;
  localparam int NUM_UNI   = 15;
  localparam int NUM_BOOT  = 4;
  localparam int NSEC      = NUM_UNI + NUM_BOOT;
  localparam int IDX_W     = $clog2(NSEC);
  localparam int BLK_W     = MEM_AW - UNI_LOG2;
  localparam int LOCK_BIT  = 7;
  localparam int GBL_LO    = 2;
  localparam int GBL_HI    = 5;
  localparam int E4K_LOG2  = 12;
  localparam int E32K_LOG2 = 15;
  localparam int E64K_LOG2 = 16;
  localparam logic [UNI_LOG2-1:0] BOOT_A_END = 16'h4000;
  localparam logic [UNI_LOG2-1:0] BOOT_B_END = 16'h6000;
  localparam logic [UNI_LOG2-1:0] BOOT_C_END = 16'h8000;

  typedef enum logic [2:0] {
    K_PROG  = 3'd0,
    K_ER4K  = 3'd1,
    K_ER32K = 3'd2,
    K_ER64K = 3'd3,
    K_CHIP  = 3'd4
  } op_kind_e;
endpackage

// File: rtl/sg_sector_map.sv
module sg_sector_map
  import sg_pkg::*;
(
  input  logic [MEM_AW-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [BLK_W-1:0] UNI_LIM = BLK_W'(NUM_UNI);

  logic [BLK_W-1:0]    blk;
  logic [UNI_LOG2-1:0] off;

  assign blk = addr[MEM_AW-1:UNI_LOG2];
  assign off = addr[UNI_LOG2-1:0];

  always_comb begin
    if (blk < UNI_LIM)          idx = IDX_W'(blk);
    else if (off < BOOT_A_END)  idx = IDX_W'(NUM_UNI);
    else if (off < BOOT_B_END)  idx = IDX_W'(NUM_UNI + 1);
    else if (off < BOOT_C_END)  idx = IDX_W'(NUM_UNI + 2);
    else                        idx = IDX_W'(NUM_UNI + 3);
  end
endmodule

// File: rtl/sg_prot_bits.sv
module sg_prot_bits
  import sg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wel,
  input  logic             wp_n,
  input  logic             op_set,
  input  logic             op_clr,
  input  logic             addr_full,
  input  logic [IDX_W-1:0] op_idx,
  input  logic             sr_wr,
  input  logic [7:0]       sr_data,
  output logic [NSEC-1:0]  bits_q,
  output logic             lock_q
);
  logic sect_ok;
  assign sect_ok = wel && addr_full && !lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '1;
      lock_q <= 1'b0;
    end else if (sr_wr && wel) begin
      if (!lock_q) begin
        lock_q <= sr_data[LOCK_BIT];
        if (sr_data == 8'h00)                bits_q <= '0;
        else if (&sr_data[GBL_HI:GBL_LO])    bits_q <= '1;
      end else if (wp_n) begin
        lock_q <= sr_data[LOCK_BIT];
      end
    end else if (sect_ok && op_set) begin
      bits_q[op_idx] <= 1'b1;
    end else if (sect_ok && op_clr) begin
      bits_q[op_idx] <= 1'b0;
    end
  end

  assert_lock_freeze_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(bits_q));

  assert_wp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !wp_n) |=> lock_q);

  assert_need_wel_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wel |=> ($stable(bits_q) && $stable(lock_q)));

  assert_discard_short_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_set || op_clr) && !addr_full && !sr_wr) |=> $stable(bits_q));
endmodule

// File: rtl/sg_summary.sv
module sg_summary
  import sg_pkg::*;
(
  input  logic [NSEC-1:0] bits,
  output logic [1:0]      swp
);
  logic any_on, all_on;
  assign any_on = |bits;
  assign all_on = &bits;

  always_comb begin
    if (all_on)      swp = 2'b11;
    else if (any_on) swp = 2'b01;
    else             swp = 2'b00;
  end
endmodule

// File: rtl/sg_sector_guard.sv
module sg_sector_guard
  import sg_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wel,
  input  logic              wp_n,
  input  logic              cmd_prot,
  input  logic              cmd_unprot,
  input  logic              cmd_addr_full,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              sr_wr,
  input  logic [7:0]        sr_data,
  output logic              wel_clr,
  output logic              lock,
  output logic [1:0]        swp,
  input  logic [2:0]        chk_kind,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              chk_prot,
  input  logic [ADDR_W-1:0] rb_addr,
  output logic              rb_prot
);
  logic [NSEC-1:0]   bits;
  logic [IDX_W-1:0]  cmd_idx, rb_idx, lo_idx, hi_idx;
  logic [MEM_AW-1:0] span, base_a, last_a;
  logic [NSEC-1:0]   in_span;
  op_kind_e          kind;
  logic              unused_hi;

  assign unused_hi = ^{cmd_addr[ADDR_W-1:MEM_AW], chk_addr[ADDR_W-1:MEM_AW],
                       rb_addr[ADDR_W-1:MEM_AW]};

  sg_sector_map u_map_cmd (.addr(cmd_addr[MEM_AW-1:0]), .idx(cmd_idx));
  sg_sector_map u_map_rb  (.addr(rb_addr[MEM_AW-1:0]),  .idx(rb_idx));
  sg_sector_map u_map_lo  (.addr(base_a),               .idx(lo_idx));
  sg_sector_map u_map_hi  (.addr(last_a),               .idx(hi_idx));

  sg_prot_bits u_bits (
    .clk(clk), .rst_n(rst_n), .wel(wel), .wp_n(wp_n),
    .op_set(cmd_prot), .op_clr(cmd_unprot), .addr_full(cmd_addr_full),
    .op_idx(cmd_idx), .sr_wr(sr_wr), .sr_data(sr_data),
    .bits_q(bits), .lock_q(lock)
  );

  sg_summary u_sum (.bits(bits), .swp(swp));

  assign wel_clr = wel && (sr_wr || ((cmd_prot || cmd_unprot) && cmd_addr_full));
  assign rb_prot = bits[rb_idx];

  assign kind = op_kind_e'(chk_kind);
  always_comb begin
    case (kind)
      K_PROG:  span = '0;
      K_ER4K:  span = MEM_AW'((1 << E4K_LOG2) - 1);
      K_ER32K: span = MEM_AW'((1 << E32K_LOG2) - 1);
      K_ER64K: span = MEM_AW'((1 << E64K_LOG2) - 1);
      default: span = '1;
    endcase
  end
  assign base_a = chk_addr[MEM_AW-1:0] & ~span;
  assign last_a = chk_addr[MEM_AW-1:0] | span;

  for (genvar i = 0; i < NSEC; i++) begin : g_span
    assign in_span[i] = (IDX_W'(i) >= lo_idx) && (IDX_W'(i) <= hi_idx);
  end

  assign chk_prot = |(bits & in_span);

  always_comb begin
    if (rst_n) assert_swp_code_R7: assert (swp != 2'b10);
  end

  assert_span_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lo_idx <= hi_idx);
endmodule

// File: tb/sim_sg_sector_guard.sv
`timescale 1ns/1ps
module sim_sg_sector_guard;
  logic clk = 0, rst_n = 0;
  logic wel = 0, wp_n = 1, cmd_prot = 0, cmd_unprot = 0, cmd_addr_full = 0;
  logic [23:0] cmd_addr = 0, chk_addr = 0, rb_addr = 0;
  logic sr_wr = 0;
  logic [7:0] sr_data = 0;
  logic [2:0] chk_kind = 0;
  logic wel_clr, lock, chk_prot, rb_prot;
  logic [1:0] swp;
  int nchk = 0, nbad = 0;
  logic [18:0] model;

  always #10 clk = ~clk;

  sg_sector_guard u0 (.*);

  function automatic int sec_of(input logic [19:0] a);
    if (a < 20'hF0000) return int'(a >> 16);
    if (a < 20'hF4000) return 15;
    if (a < 20'hF6000) return 16;
    if (a < 20'hF8000) return 17;
    return 18;
  endfunction

  function automatic logic [19:0] sec_base(input int s);
    case (s)
      15: return 20'hF0000;
      16: return 20'hF4000;
      17: return 20'hF6000;
      18: return 20'hF8000;
      default: return 20'(s) << 16;
    endcase
  endfunction

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    for (int s = 0; s < 19; s++) begin
      rb_addr = {4'h0, sec_base(s)};
      #1;
      chk(rb_prot == model[s], req, $sformatf("sector %0d bit", s), rb_prot, model[s]);
    end
  endtask

  task automatic exp_swp(input string req);
    logic [1:0] e;
    e = (&model) ? 2'b11 : ((|model) ? 2'b01 : 2'b00);
    chk(swp == e, req, "swp", swp, e);
  endtask

  task automatic sect_cmd(input logic [23:0] a, input logic full, input logic w,
                          input logic setp, input logic exp_clr, input string req);
    @(negedge clk);
    cmd_addr = a; cmd_addr_full = full; wel = w;
    cmd_prot = setp; cmd_unprot = !setp;
    #1;
    chk(wel_clr == exp_clr, req, "wel_clr on sector strobe", wel_clr, exp_clr);
    @(negedge clk);
    cmd_prot = 0; cmd_unprot = 0; wel = 0; cmd_addr_full = 0;
  endtask

  task automatic sr_cmd(input logic [7:0] d, input logic w, input string req);
    @(negedge clk);
    sr_data = d; wel = w; sr_wr = 1;
    #1;
    chk(wel_clr == w, req, "wel_clr on status write", wel_clr, w);
    @(negedge clk);
    sr_wr = 0; wel = 0;
  endtask

  function automatic logic exp_chk(input logic [2:0] k, input logic [19:0] a);
    logic [19:0] m;
    int lo, hi;
    case (k)
      3'd0: m = 20'h0;
      3'd1: m = 20'h00FFF;
      3'd2: m = 20'h07FFF;
      3'd3: m = 20'h0FFFF;
      default: m = 20'hFFFFF;
    endcase
    lo = sec_of(a & ~m);
    hi = sec_of(a | m);
    for (int s = lo; s <= hi; s++) if (model[s]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic probe(input logic [2:0] k, input logic [23:0] a, input string req);
    chk_kind = k; chk_addr = a;
    #1;
    chk(chk_prot == exp_chk(k, a[19:0]), req,
        $sformatf("chk_prot kind %0d addr %0h", k, a), chk_prot, exp_chk(k, a[19:0]));
  endtask

  task automatic t_reset;
    model = '1;
    chk(lock == 0, "R3", "lock after reset", lock, 0);
    chk(swp == 2'b11, "R3", "swp after reset", swp, 3);
    chk_all("R3");
  endtask

  task automatic t_global;
    sr_cmd(8'h00, 1, "R10");
    model = '0;
    chk_all("R4"); exp_swp("R7");
    sr_cmd(8'h3C, 1, "R4");
    model = '1;
    chk_all("R4"); exp_swp("R7");
    sr_cmd(8'h00, 1, "R4");
    model = '0;
    sr_cmd(8'h1C, 1, "R4");
    chk_all("R4");
    sr_cmd(8'h3C, 0, "R2");
    chk_all("R4");
  endtask

  task automatic t_map;
    sect_cmd(24'hAF4000, 1, 1, 1, 1, "R10");
    model[16] = 1;
    chk_all("R1"); exp_swp("R7");
    rb_addr = 24'h0F3FFF; #1; chk(rb_prot == 0, "R1", "F3FFF", rb_prot, 0);
    rb_addr = 24'h0F5FFF; #1; chk(rb_prot == 1, "R1", "F5FFF", rb_prot, 1);
    rb_addr = 24'h0F6000; #1; chk(rb_prot == 0, "R1", "F6000", rb_prot, 0);
    sect_cmd(24'h0FFFFF, 1, 1, 1, 1, "R2");
    model[18] = 1;
    sect_cmd(24'h030000, 1, 1, 1, 1, "R2");
    model[3] = 1;
    chk_all("R2");
  endtask

  task automatic t_reject;
    sect_cmd(24'h050000, 0, 1, 1, 0, "R2");
    sect_cmd(24'h060000, 1, 0, 1, 0, "R2");
    chk_all("R2");
    sect_cmd(24'h030123, 1, 1, 0, 1, "R2");
    model[3] = 0;
    chk_all("R2");
  endtask

  task automatic t_check;
    probe(3'd0, 24'h0F4010, "R8");
    probe(3'd0, 24'h0F6010, "R8");
    probe(3'd1, 24'h010000, "R8");
    probe(3'd2, 24'h0F1234, "R9");
    probe(3'd2, 24'h0F9000, "R9");
    probe(3'd3, 24'h0F0000, "R9");
    probe(3'd3, 24'h0E0000, "R9");
    probe(3'd4, 24'h000000, "R9");
  endtask

  task automatic t_lock;
    sr_cmd(8'h80, 1, "R6");
    chk(lock == 1, "R6", "lock set", lock, 1);
    sect_cmd(24'h0F4000, 1, 1, 0, 1, "R5");
    sect_cmd(24'h070000, 1, 1, 1, 1, "R5");
    chk_all("R5");
    wp_n = 0;
    sr_cmd(8'h00, 1, "R6");
    chk(lock == 1, "R6", "lock held by pin", lock, 1);
    chk_all("R5");
    wp_n = 1;
    sr_cmd(8'h00, 1, "R6");
    chk(lock == 0, "R6", "lock cleared", lock, 0);
    chk_all("R5");
    sr_cmd(8'h00, 1, "R4");
    model = '0;
    chk_all("R4"); exp_swp("R7");
    probe(3'd4, 24'h000000, "R9");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_global();
    t_map();
    t_reject();
    t_check();
    t_lock();
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule